// File: doc/BRIEF.md
# Wavefront memory access coalescer

This block takes the per-lane addresses of one quarter-wavefront (sixteen lanes) in a single handshake. It packs the active lanes into as few 16-byte cache-port requests as it can. A request covers every pending lane whose address shares bits [31:4] with the request's leader. Each cycle the block offers up to four such requests side by side. Each request carries its aligned address, a byte mask, and the set of lanes it serves. A per-lane word selector maps every lane onto its 32-bit slot within the request.

The same grouping serves loads and stores alike. A store marker travels with the quarter and needs no other handling. When all four requests offered in a cycle fall inside one aligned 64-byte line, a flag marks them as a single line access. When a quarter's lanes run over consecutive aligned words, the quarter leaves in one cycle, so a whole wavefront takes four. With 64-bit data a wavefront takes eight cycles. When every lane needs its own request, it takes sixteen. The next quarter is accepted in the cycle in which the previous one hands over its last requests, so issue has no bubble between quarters.

Top module: `coal_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A request serves exactly the pending lanes whose byte address (`in_waddr` lane i holds byte address bits [31:2] in bits [29:0]) shares bits [31:4] with the request's leader. Its `out_req_addr` is those bits followed by four zero bits. Its `out_lane_mask` has bit i set for each lane it serves. No lane is served twice.
- R3: The byte mask sets bytes 4w..4w+3 for each served lane, where w is byte-address bits [3:2]. When `in_wide` is 1, the lane also sets the bytes of word (w OR 1).
- R4: The leader of each request is the lowest-numbered lane still pending. Requests fill slots 0, 1, 2, 3 in that order, at most four per cycle. A valid slot never follows an invalid one.
- R5: A quarter of 16 consecutive aligned 32-bit words issues in 1 cycle. A quarter of 16 consecutive 64-bit words issues in 2 cycles. A quarter whose lanes all sit in different 16-byte blocks issues in 4 cycles.
- R6: Lanes whose `in_active` bit is 0 appear in no request. A quarter with no active lane is consumed with zero issue cycles.
- R7: `out_same_line` is 1 exactly when all four slots are valid and their addresses share bits [31:6].
- R8: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and nothing is dropped.
- R9: `out_store` repeats the `in_store` value of the quarter being issued.
- R10: `out_lane_slot` field i (two bits at position 2i) equals byte-address bits [3:2] of lane i.
- R11: With `out_ready` held at 1, back-to-back quarters issue in consecutive cycles. A fully coalesced wavefront of four quarters spans exactly 4 issue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Quarter offered |
| in_ready | output | 1 | Quarter accepted this cycle when both are high |
| in_waddr | input | 480 | Per-lane byte address bits [31:2], lane i at bits [30i+29:30i] |
| in_active | input | 16 | Active lane mask |
| in_wide | input | 1 | 1 for 64-bit data, 0 for 32-bit |
| in_store | input | 1 | Quarter is a store |
| out_ready | input | 1 | Cache port takes the offered requests |
| out_valid | output | 1 | At least one request offered |
| out_req_vld | output | 4 | Per-slot request valid |
| out_req_addr | output | 128 | Per-slot 16-byte aligned byte address |
| out_byte_mask | output | 64 | Per-slot byte enables |
| out_lane_mask | output | 64 | Per-slot served lanes |
| out_lane_slot | output | 32 | Per-lane word index inside its request |
| out_same_line | output | 1 | All four slots fall in one 64-byte line |
| out_store | output | 1 | Store marker of the issuing quarter |

## Verification
The case that needs care is the cycle in which a quarter's last requests are handed to the port while the next quarter is accepted. Loading the new lanes and retiring the old ones both write the same pending-lane register. The bench provokes this by sending quarters back to back with the port ready, then with ready toggling pseudo-randomly. A scoreboard compares each issued cycle with a model built from the requirements. Loss or duplication at the seam shows as a mismatch, and a bubble shows as a longer issue span than expected.

// File: rtl/coal_pkg.sv
`timescale 1ns/1ps
package coal_pkg;
   // bytes per 32-bit word
   localparam int unsigned WORD_BYTES = 4;

   // enables for one word, shifted into place inside a request
   function automatic logic [63:0] word_bytes(input int unsigned w);
      return 64'hF << (WORD_BYTES * w);
   endfunction
endpackage

// File: rtl/coal_match.sv
`timescale 1ns/1ps
module coal_match #(
   parameter int unsigned LANES = 16,
   parameter int unsigned TAG_W = 28
) (
   input  logic [LANES*TAG_W-1:0] tags,
   output logic [LANES*LANES-1:0] match
);
   for (genvar i = 0; i < LANES; i++) begin : g_row
      for (genvar j = 0; j < LANES; j++) begin : g_col
         assign match[i*LANES+j] = (tags[i*TAG_W +: TAG_W] == tags[j*TAG_W +: TAG_W]);
      end
   end
endmodule

// File: rtl/coal_pick.sv
`timescale 1ns/1ps
module coal_pick #(
   parameter int unsigned LANES = 16,
   localparam int unsigned LW = $clog2(LANES)
) (
   input  logic [LANES-1:0]       remain,
   input  logic [LANES*LANES-1:0] match,
   output logic [LANES-1:0]       members,
   output logic [LANES-1:0]       rest,
   output logic [LW-1:0]          lead
);
   logic [LANES-1:0] lead_row;
   logic             found;

   always_comb begin
      found    = 1'b0;
      lead     = '0;
      lead_row = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!found && remain[i]) begin
            found    = 1'b1;
            lead     = LW'(i);
            lead_row = match[i*LANES +: LANES];
         end
      end
      members = remain & lead_row;
      rest    = remain & ~members;
   end
endmodule

// File: rtl/coal_bmask.sv
`timescale 1ns/1ps
module coal_bmask #(
   parameter int unsigned LANES = 16,
   parameter int unsigned RB    = 16
) (
   input  logic [LANES-1:0]    members,
   input  logic [LANES*RB-1:0] lane_bytes,
   output logic [RB-1:0]       bmask
);
   always_comb begin
      bmask = '0;
      for (int i = 0; i < LANES; i++)
         if (members[i]) bmask |= lane_bytes[i*RB +: RB];
   end
endmodule

// File: rtl/coal_top.sv
`timescale 1ns/1ps
module coal_top
   import coal_pkg::*;
#(
   parameter int unsigned LANES     = 16,
   parameter int unsigned SLOTS     = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned REQ_BYTES = 16,
   localparam int unsigned WA_W   = ADDR_W - 2,
   localparam int unsigned OFF_W  = $clog2(REQ_BYTES),
   localparam int unsigned WSEL_W = OFF_W - 2,
   localparam int unsigned TAG_W  = ADDR_W - OFF_W,
   localparam int unsigned LINE_W = OFF_W + $clog2(SLOTS),
   localparam int unsigned LW     = $clog2(LANES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [LANES*WA_W-1:0]     in_waddr,
   input  logic [LANES-1:0]          in_active,
   input  logic                      in_wide,
   input  logic                      in_store,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [SLOTS-1:0]          out_req_vld,
   output logic [SLOTS*ADDR_W-1:0]   out_req_addr,
   output logic [SLOTS*REQ_BYTES-1:0] out_byte_mask,
   output logic [SLOTS*LANES-1:0]    out_lane_mask,
   output logic [LANES*WSEL_W-1:0]   out_lane_slot,
   output logic                      out_same_line,
   output logic                      out_store
);
   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (SLOTS < 1 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two");
   end
   if (REQ_BYTES < 8 || REQ_BYTES > 64 || (REQ_BYTES & (REQ_BYTES - 1)) != 0) begin : g_bad_req
      $error("REQ_BYTES must be a power of two from 8 to 64");
   end
   if (ADDR_W <= LINE_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [LANES-1:0][WA_W-1:0]      q_wa;
   logic [LANES-1:0]                q_pend;
   logic                            q_wide;
   logic                            q_store;
   logic [LANES-1:0][TAG_W-1:0]     tag_arr;
   logic [LANES-1:0][REQ_BYTES-1:0] lane_bytes;
   logic [LANES*LANES-1:0]          match;
   logic [SLOTS:0][LANES-1:0]       rem;
   logic [SLOTS-1:0][LANES-1:0]     mem;
   logic [SLOTS-1:0][LW-1:0]        lead;
   logic [SLOTS-1:0][TAG_W-1:0]     req_tag;
   logic                            accept;
   logic                            xfer;

   assign out_valid = |q_pend;
   assign in_ready  = !out_valid || (out_ready && rem[SLOTS] == '0);
   assign accept    = in_valid && in_ready;
   assign xfer      = out_valid && out_ready;
   assign out_store = q_store;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_pend  <= '0;
         q_wide  <= 1'b0;
         q_store <= 1'b0;
         q_wa    <= '0;
      end else if (accept) begin
         q_pend  <= in_active;
         q_wide  <= in_wide;
         q_store <= in_store;
         q_wa    <= in_waddr;
      end else if (xfer) begin
         q_pend  <= rem[SLOTS];
      end
   end

   // per-lane tag, word selector and byte enables
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [WSEL_W-1:0] w;
      assign w          = q_wa[i][WSEL_W-1:0];
      assign tag_arr[i] = q_wa[i][WA_W-1:WSEL_W];
      assign out_lane_slot[i*WSEL_W +: WSEL_W] = w;
      assign lane_bytes[i] = REQ_BYTES'(word_bytes(int'(w)))
                           | (q_wide ? REQ_BYTES'(word_bytes(int'(w | WSEL_W'(1)))) : '0);
   end

   coal_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
      .tags  (tag_arr),
      .match (match)
   );

   assign rem[0] = q_pend;

   // one picker per slot, chained on the lanes left over
   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      coal_pick #(.LANES(LANES)) u_pick (
         .remain  (rem[k]),
         .match   (match),
         .members (mem[k]),
         .rest    (rem[k+1]),
         .lead    (lead[k])
      );
      coal_bmask #(.LANES(LANES), .RB(REQ_BYTES)) u_bm (
         .members    (mem[k]),
         .lane_bytes (lane_bytes),
         .bmask      (out_byte_mask[k*REQ_BYTES +: REQ_BYTES])
      );
      assign req_tag[k]       = tag_arr[lead[k]];
      assign out_req_vld[k]   = |mem[k];
      assign out_lane_mask[k*LANES +: LANES]   = mem[k];
      assign out_req_addr[k*ADDR_W +: ADDR_W]  = {req_tag[k], {OFF_W{1'b0}}};

      if (k > 0) begin : g_order
         // R4
         slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_req_vld[k] |-> out_req_vld[k-1]);
      end
   end

   always_comb begin
      out_same_line = &out_req_vld;
      for (int k = 1; k < SLOTS; k++)
         if (req_tag[k][TAG_W-1:LINE_W-OFF_W] != req_tag[0][TAG_W-1:LINE_W-OFF_W])
            out_same_line = 1'b0;
   end

   // checking logic
   logic [LANES-1:0] lm_or;
   int unsigned      lm_sum;
   always_comb begin
      lm_or  = '0;
      lm_sum = 0;
      for (int k = 0; k < SLOTS; k++) begin
         lm_or  |= mem[k];
         lm_sum += $countones(mem[k]);
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid && in_ready);
   // R2
   lane_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(lm_or) == lm_sum);
   // R6
   active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_req_vld[0] && (lm_or & ~q_pend) == '0);
   // R7
   line_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_same_line |-> &out_req_vld);
   // R8
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_req_vld)
         && $stable(out_req_addr) && $stable(out_lane_mask)
         && $stable(out_byte_mask) && $stable(out_store));
endmodule

// File: tb/sim_coal_top.sv
`timescale 1ns/1ps
module sim_coal_top;
   typedef struct packed {
      logic [3:0]        vld;
      logic [3:0][31:0]  a;
      logic [3:0][15:0]  bm;
      logic [3:0][15:0]  lm;
      logic              sl;
      logic              st;
      logic [15:0][1:0]  slot;
   } exp_t;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         in_valid = 0;
   logic         in_ready;
   logic [479:0] in_waddr = '0;
   logic [15:0]  in_active = '0;
   logic         in_wide = 0;
   logic         in_store = 0;
   logic         out_ready = 1;
   logic         out_valid;
   logic [3:0]   out_req_vld;
   logic [127:0] out_req_addr;
   logic [63:0]  out_byte_mask;
   logic [63:0]  out_lane_mask;
   logic [31:0]  out_lane_slot;
   logic         out_same_line;
   logic         out_store;

   int   errors = 0;
   int   checks = 0;
   exp_t sbq[$];
   int   cyc = 0;
   int   xfers = 0;
   int   first_c = -1;
   int   last_c = -1;
   bit   rdy_rand = 0;
   bit   stall_prev = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;
   logic [127:0] sv_addr;
   logic [63:0]  sv_lm;
   logic [63:0]  sv_bm;
   logic [3:0]   sv_vld;

   always #5 clk = ~clk;

   coal_top u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] step(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // expected issue cycles, built from the requirements
   task automatic push_exp(input logic [15:0][29:0] wa, input logic [15:0] act,
                           input logic wide, input logic st);
      logic [15:0] pend;
      pend = act;
      while (pend != 0) begin
         exp_t e;
         e = '0;
         e.st = st;
         for (int i = 0; i < 16; i++) e.slot[i] = wa[i][1:0];
         for (int k = 0; k < 4; k++) begin
            int l;
            l = -1;
            for (int i = 15; i >= 0; i--) if (pend[i]) l = i;
            if (l >= 0) begin
               for (int i = 0; i < 16; i++) begin
                  if (pend[i] && wa[i][29:2] == wa[l][29:2]) begin
                     int w;
                     w = int'(wa[i][1:0]);
                     e.lm[k][i] = 1'b1;
                     e.bm[k] |= 16'hF << (4*w);
                     if (wide) e.bm[k] |= 16'hF << (4*(w | 1));
                  end
               end
               pend &= ~e.lm[k];
               e.vld[k] = 1'b1;
               e.a[k] = {wa[l][29:2], 4'b0};
            end
         end
         e.sl = &e.vld;
         for (int k = 1; k < 4; k++) if (e.a[k][31:6] != e.a[0][31:6]) e.sl = 1'b0;
         sbq.push_back(e);
      end
   endtask

   // driver: called just after a falling edge, returns after the next one
   task automatic send(input logic [15:0][29:0] wa, input logic [15:0] act,
                       input logic wide, input logic st);
      in_waddr  = wa;
      in_active = act;
      in_wide   = wide;
      in_store  = st;
      in_valid  = 1;
      forever begin
         #2;
         if (in_ready) break;
         @(negedge clk);
      end
      push_exp(wa, act, wide, st);
      @(posedge clk);
      #1 in_valid = 0;
      @(negedge clk);
   endtask

   task automatic drain();
      while (sbq.size() != 0 || out_valid) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic phase_start();
      xfers = 0;
      first_c = -1;
      last_c = -1;
   endtask

   // monitor and scoreboard
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n && out_valid) begin
            if (stall_prev) begin
               // R8: held while stalled
               chk(out_req_addr == sv_addr && out_lane_mask == sv_lm &&
                   out_byte_mask == sv_bm && out_req_vld == sv_vld,
                   "R8", "hold under stall", out_req_addr, sv_addr);
            end
            if (sbq.size() == 0) begin
               chk(0, "R6", "unexpected request", {124'b0, out_req_vld}, 128'b0);
            end else begin
               exp_t e;
               e = sbq[0];
               // R2 R4: slot validity, lane sets and addresses
               chk(out_req_vld == e.vld, "R4", "slot valid", {124'b0, out_req_vld}, {124'b0, e.vld});
               chk(out_lane_mask == e.lm, "R2", "lane mask", {64'b0, out_lane_mask}, {64'b0, e.lm});
               for (int k = 0; k < 4; k++) if (e.vld[k]) begin
                  chk(out_req_addr[k*32 +: 32] == e.a[k], "R2", "request address",
                      {96'b0, out_req_addr[k*32 +: 32]}, {96'b0, e.a[k]});
                  // R3
                  chk(out_byte_mask[k*16 +: 16] == e.bm[k], "R3", "byte mask",
                      {112'b0, out_byte_mask[k*16 +: 16]}, {112'b0, e.bm[k]});
               end
               // R7
               chk(out_same_line == e.sl, "R7", "same line flag", {127'b0, out_same_line}, {127'b0, e.sl});
               // R9
               chk(out_store == e.st, "R9", "store marker", {127'b0, out_store}, {127'b0, e.st});
               // R10
               chk(out_lane_slot == e.slot, "R10", "lane slot", {96'b0, out_lane_slot}, {96'b0, e.slot});
            end
         end
         lfsr = step(lfsr);
         out_ready = rdy_rand ? lfsr[3] : 1'b1;
         if (rst_n && out_valid && out_ready) begin
            if (sbq.size() != 0) void'(sbq.pop_front());
            xfers++;
            if (first_c < 0) first_c = cyc;
            last_c = cyc;
         end
         stall_prev = rst_n && out_valid && !out_ready;
         sv_addr = out_req_addr;
         sv_lm   = out_lane_mask;
         sv_bm   = out_byte_mask;
         sv_vld  = out_req_vld;
      end
   end

   // watchdog
   initial begin
      #1_500_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0][29:0] wa;
      logic [31:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #2;
      // R1
      chk(!out_valid && in_ready, "R1", "reset state", {126'b0, out_valid, in_ready}, 128'b1);

      // R5 R11: fully coalesced 32-bit wavefront, ready held high
      phase_start();
      base = 32'h0000_1000;
      for (int q = 0; q < 4; q++) begin
         for (int i = 0; i < 16; i++) wa[i] = 30'((base + q*64 + 4*i) >> 2);
         send(wa, 16'hFFFF, 1'b0, 1'b0);
      end
      drain();
      chk(xfers == 4, "R5", "coalesced cycles", 128'(xfers), 128'd4);
      chk(last_c - first_c + 1 == 4, "R11", "issue span", 128'(last_c - first_c + 1), 128'd4);

      // R5: 64-bit wavefront, stores
      phase_start();
      base = 32'h0002_0000;
      for (int q = 0; q < 4; q++) begin
         for (int i = 0; i < 16; i++) wa[i] = 30'((base + q*128 + 8*i) >> 2);
         send(wa, 16'hFFFF, 1'b1, 1'b1);
      end
      drain();
      chk(xfers == 8, "R5", "wide cycles", 128'(xfers), 128'd8);

      // R5: every lane in its own block
      phase_start();
      base = 32'h0010_0004;
      for (int q = 0; q < 4; q++) begin
         for (int i = 0; i < 16; i++) wa[i] = 30'((base + q*4096 + 256*i) >> 2);
         send(wa, 16'hFFFF, 1'b0, 1'b0);
      end
      drain();
      chk(xfers == 16, "R5", "scattered cycles", 128'(xfers), 128'd16);

      // R6: quarter with no active lanes, then a partial one
      phase_start();
      send(wa, 16'h0000, 1'b0, 1'b0);
      drain();
      chk(xfers == 0, "R6", "empty quarter cycles", 128'(xfers), 128'd0);
      for (int i = 0; i < 16; i++) wa[i] = 30'((32'h3000 + 4*i) >> 2);
      phase_start();
      send(wa, 16'h0F0A, 1'b0, 1'b1);
      drain();
      chk(xfers == 1, "R6", "partial quarter cycles", 128'(xfers), 128'd1);

      // R4 R8: mixed grouping under random back-pressure
      rdy_rand = 1;
      for (int n = 0; n < 60; n++) begin
         logic [31:0] r;
         logic wide;
         r = lfsr;
         wide = r[7];
         for (int i = 0; i < 16; i++) begin
            r = step(r);
            wa[i] = 30'((32'h0004_0000 + 16*(r % 7) + (wide ? 8*r[5] : 4*r[6:5])) >> 2);
         end
         r = step(r);
         send(wa, r[15:0] | 16'h0100, wide, r[20]);
      end
      drain();
      rdy_rand = 0;
      @(negedge clk);
      chk(sbq.size() == 0 && !out_valid, "R8", "nothing lost", 128'(sbq.size()), 128'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule